// File: doc/BRIEF.md
# Hardware Mutex Register Bank

A bank of single-bit hardware mutexes that several bus masters share to serialise use of common resources. Each mutex has its own word-aligned register. Claiming a mutex takes a single read: if the mutex is free the read returns 0 and the same access marks it taken, so no read-modify-write sequence is needed. Software that reads 1 knows another master owns the mutex and retries later. The owner gives the mutex back by writing 0 to its register.

A read-only status word tells software how many mutexes the bank provides. The bank size is a parameter limited to 32, 64, 128 or 256. The slave port accepts one access per clock and answers each one with a ready pulse and read data on the following cycle. Two accesses are therefore always strictly ordered, which makes the claim atomic.

Top module: `hwmutex_bank`

## Requirements
- R1: Mutex state is encoded 0 = free, 1 = taken. A read of a free mutex returns 0 in rdata (all bits 0) and leaves that mutex taken.
- R2: A read of a taken mutex returns 1 in rdata bit 0, with all other bits 0, and the mutex stays taken.
- R3: A write of data 0 to a mutex register makes that mutex free.
- R4: A write of any nonzero data to a mutex register is ignored, and the mutex keeps its state.
- R5: Mutex i sits at byte address 0x800 + 4*i, for i from 0 to NUM_LOCKS-1. An access changes only the mutex it addresses.
- R6: A read of byte address 0x14 returns NUM_LOCKS/32 in bits 27:24 and 0 in every other bit. Writes to it are ignored.
- R7: Reads of unmapped addresses return 0 and change no mutex. This covers addresses that are not word aligned and indices at or beyond NUM_LOCKS. Writes to unmapped addresses change no mutex.
- R8: Every request is answered by ready high, with its read data, on the cycle after the request. Ready is low on the cycle after a cycle with no request. Back-to-back reads of one free mutex return 0 and then 1.
- R9: Synchronous reset makes every mutex free and drives ready and rdata low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while ready is high |
| ready | output | 1 | Access completion, one cycle after req |

## Verification
The claim path is tried with a first read of a free mutex, with repeated reads of a held mutex, and with back-to-back reads of one mutex in consecutive cycles. These tell a correct test-and-set apart from a plain read, and from a read that reports the already-updated value. Release is tried with a zero write and with nonzero writes. The nonzero case shows whether the bank tests for data equal to zero rather than looking at bit 0 alone. Neighbouring mutexes, the last valid index, the first index past the end, a misaligned address and the status word are used to show that decode touches exactly one mutex. A reset in the middle of a run, with mutexes held, shows that all state clears.

// File: rtl/hwmutex_pkg.sv
package hwmutex_pkg;
    localparam int unsigned DATA_W         = 32;
    localparam int unsigned LOCK_BASE      = 'h800;
    localparam int unsigned STATUS_ADDR    = 'h14;
    localparam int unsigned CODE_LSB       = 24;
    localparam int unsigned LOCKS_PER_CODE = 32;

    typedef struct packed {
        logic              ready;
        logic [DATA_W-1:0] rdata;
    } resp_t;
endpackage

// File: rtl/hwmutex_decode.sv
module hwmutex_decode #(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned ADDR_W    = 12,
    localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_lock,
    output logic              hit_status,
    output logic [IDX_W-1:0]  lock_idx
);
    import hwmutex_pkg::*;

    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(LOCK_BASE);
    localparam logic [ADDR_W-1:0] WIN_A    = ADDR_W'(NUM_LOCKS * 4);
    localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_ADDR);

    logic [ADDR_W-1:0] ofs;

    always_comb begin
        ofs        = addr - BASE_A;
        hit_lock   = (addr >= BASE_A) && (ofs < WIN_A) && (ofs[1:0] == 2'b00);
        hit_status = (addr == STATUS_A);
        lock_idx   = ofs[IDX_W+1:2];
    end
endmodule

// File: rtl/hwmutex_locks.sv
module hwmutex_locks #(
    parameter int unsigned NUM_LOCKS = 32,
    localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acquire,
    input  logic                 release_req,
    input  logic [IDX_W-1:0]     idx,
    output logic [NUM_LOCKS-1:0] state,
    output logic                 cur_bit
);
    logic [NUM_LOCKS-1:0] state_d;
    logic [NUM_LOCKS-1:0] state_q;

    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
        always_comb begin
            state_d[g] = state_q[g];
            if (idx == IDX_W'(g)) begin
                if (acquire)
                    state_d[g] = 1'b1;
                else if (release_req)
                    state_d[g] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign state   = state_q;
    assign cur_bit = state_q[idx];
endmodule

// File: rtl/hwmutex_bank.sv
module hwmutex_bank #(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              ready
);
    import hwmutex_pkg::*;

    localparam int unsigned IDX_W = $clog2(NUM_LOCKS);
    localparam logic [DATA_W-1:0] STATUS_WORD =
        DATA_W'(NUM_LOCKS / LOCKS_PER_CODE) << CODE_LSB;

    logic                 hit_lock;
    logic                 hit_status;
    logic [IDX_W-1:0]     lock_idx;
    logic [NUM_LOCKS-1:0] lock_vec;
    logic                 cur_bit;
    logic                 do_acq;
    logic                 do_rel;
    resp_t                resp_d;
    resp_t                resp_q;

    hwmutex_decode #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_dec (
        .addr       (addr),
        .hit_lock   (hit_lock),
        .hit_status (hit_status),
        .lock_idx   (lock_idx)
    );

    assign do_acq = req && !we && hit_lock;
    assign do_rel = req && we && hit_lock && (wdata == '0);

    hwmutex_locks #(.NUM_LOCKS(NUM_LOCKS)) u_locks (
        .clk         (clk),
        .rst         (rst),
        .acquire     (do_acq),
        .release_req (do_rel),
        .idx         (lock_idx),
        .state       (lock_vec),
        .cur_bit     (cur_bit)
    );

    always_comb begin
        resp_d       = '0;
        resp_d.ready = req;
        if (req && !we) begin
            if (hit_lock)
                resp_d.rdata = DATA_W'(cur_bit);
            else if (hit_status)
                resp_d.rdata = STATUS_WORD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            resp_q <= '0;
        else
            resp_q <= resp_d;
    end

    assign rdata = resp_q.rdata;
    assign ready = resp_q.ready;
endmodule

// File: rtl/hwmutex_checker.sv
module hwmutex_checker #(
    parameter int unsigned NUM_LOCKS = 32,
    parameter int unsigned ADDR_W    = 12,
    localparam int unsigned IDX_W    = $clog2(NUM_LOCKS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req,
    input logic                 we,
    input logic [ADDR_W-1:0]    addr,
    input logic [31:0]          wdata,
    input logic [31:0]          rdata,
    input logic                 ready,
    input logic                 hit_lock,
    input logic                 hit_status,
    input logic [IDX_W-1:0]     lock_idx,
    input logic [NUM_LOCKS-1:0] lock_vec
);
    localparam logic [31:0] EXP_STATUS = 32'(NUM_LOCKS / 32) << 24;

    assert_free_read_R1: assert property (@(posedge clk) disable iff (rst)
        (req && !we && hit_lock && !lock_vec[lock_idx])
        |=> (rdata == 32'd0) && lock_vec[$past(lock_idx)]);

    assert_taken_read_R2: assert property (@(posedge clk) disable iff (rst)
        (req && !we && hit_lock && lock_vec[lock_idx])
        |=> (rdata == 32'd1) && lock_vec[$past(lock_idx)]);

    assert_release_R3: assert property (@(posedge clk) disable iff (rst)
        (req && we && hit_lock && wdata == 32'd0)
        |=> !lock_vec[$past(lock_idx)]);

    assert_nonzero_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (req && we && wdata != 32'd0) |=> $stable(lock_vec));

    assert_status_R6: assert property (@(posedge clk) disable iff (rst)
        (req && !we && hit_status) |=> rdata == EXP_STATUS);

    assert_unmapped_state_R7: assert property (@(posedge clk) disable iff (rst)
        (req && !hit_lock) |=> $stable(lock_vec));

    assert_unmapped_data_R7: assert property (@(posedge clk) disable iff (rst)
        (req && !we && !hit_lock && !hit_status) |=> rdata == 32'd0);

    assert_ready_R8: assert property (@(posedge clk) disable iff (rst)
        req |=> ready);

    assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !req |=> !ready);

    assert_one_change_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(lock_vec ^ $past(lock_vec)) <= 1);
endmodule

bind hwmutex_bank hwmutex_checker #(.NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .we         (we),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .ready      (ready),
    .hit_lock   (hit_lock),
    .hit_status (hit_status),
    .lock_idx   (lock_idx),
    .lock_vec   (lock_vec)
);

// File: tb/hwmutex_bank_test.sv
module hwmutex_bank_test;
    localparam int unsigned NL = 32;
    localparam int unsigned AW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          we  = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          ready;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    hwmutex_bank #(.NUM_LOCKS(NL), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready)
    );

    function automatic logic [AW-1:0] lk(input int i);
        return AW'(32'h800 + 4 * i);
    endfunction

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        rd = rdata;
        check("R8 ready", 32'(ready), 32'd1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R9 ready after reset", 32'(ready), 32'd0);
        check("R9 rdata after reset", rdata, 32'd0);
        for (int i = 0; i < int'(NL); i += 7) begin
            access(1'b0, lk(i), 32'd0, r);
            check("R9 free after reset", r, 32'd0);
        end
    endtask

    task automatic t_acquire();
        logic [31:0] r;
        do_reset();
        access(1'b0, lk(3), 32'd0, r);
        check("R1 free read", r, 32'd0);
        access(1'b0, lk(3), 32'd0, r);
        check("R2 taken read", r, 32'd1);
        access(1'b0, lk(3), 32'd0, r);
        check("R2 still taken", r, 32'd1);
    endtask

    task automatic t_release();
        logic [31:0] r;
        do_reset();
        access(1'b0, lk(9), 32'd0, r);
        access(1'b1, lk(9), 32'd0, r);
        access(1'b0, lk(9), 32'd0, r);
        check("R3 freed by zero write", r, 32'd0);
    endtask

    task automatic t_nonzero();
        logic [31:0] r;
        do_reset();
        access(1'b0, lk(4), 32'd0, r);
        access(1'b1, lk(4), 32'h0000_0002, r);
        access(1'b1, lk(4), 32'h8000_0000, r);
        access(1'b0, lk(4), 32'd0, r);
        check("R4 held after nonzero writes", r, 32'd1);
        access(1'b1, lk(5), 32'd1, r);
        access(1'b0, lk(5), 32'd0, r);
        check("R4 free stays free", r, 32'd0);
    endtask

    task automatic t_map();
        logic [31:0] r;
        do_reset();
        access(1'b0, lk(0), 32'd0, r);
        access(1'b0, lk(1), 32'd0, r);
        check("R5 neighbour independent", r, 32'd0);
        access(1'b0, lk(NL - 1), 32'd0, r);
        check("R5 last index free", r, 32'd0);
        access(1'b0, lk(NL - 1), 32'd0, r);
        check("R5 last index taken", r, 32'd1);
        access(1'b1, lk(1), 32'd0, r);
        access(1'b0, lk(0), 32'd0, r);
        check("R5 lock0 unaffected by lock1 release", r, 32'd1);
    endtask

    task automatic t_status();
        logic [31:0] r;
        access(1'b0, AW'(12'h014), 32'd0, r);
        check("R6 status", r, 32'(NL / 32) << 24);
        access(1'b1, AW'(12'h014), 32'd0, r);
        access(1'b0, AW'(12'h014), 32'd0, r);
        check("R6 status after write", r, 32'(NL / 32) << 24);
    endtask

    task automatic t_unmapped();
        logic [31:0] r;
        do_reset();
        access(1'b0, lk(NL), 32'd0, r);
        check("R7 past end reads 0", r, 32'd0);
        access(1'b0, lk(NL), 32'd0, r);
        check("R7 past end no side effect", r, 32'd0);
        access(1'b0, lk(2) + AW'(1), 32'd0, r);
        check("R7 misaligned reads 0", r, 32'd0);
        access(1'b0, lk(2), 32'd0, r);
        check("R7 misaligned did not claim", r, 32'd0);
        access(1'b0, AW'(12'h010), 32'd0, r);
        check("R7 unmapped low reads 0", r, 32'd0);
        access(1'b1, lk(2) + AW'(2), 32'd0, r);
        access(1'b0, lk(2), 32'd0, r);
        check("R7 misaligned write ignored", r, 32'd1);
    endtask

    task automatic t_b2b();
        do_reset();
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = lk(7);
        @(negedge clk);
        check("R8 first b2b ready", 32'(ready), 32'd1);
        check("R8 first b2b read", rdata, 32'd0);
        @(negedge clk);
        req = 1'b0;
        check("R8 second b2b read", rdata, 32'd1);
        @(negedge clk);
        check("R8 idle ready low", 32'(ready), 32'd0);
    endtask

    task automatic t_reset_mid();
        logic [31:0] r;
        access(1'b0, lk(11), 32'd0, r);
        do_reset();
        access(1'b0, lk(11), 32'd0, r);
        check("R9 reset frees held mutex", r, 32'd0);
        access(1'b0, lk(7), 32'd0, r);
        check("R9 reset frees other mutex", r, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_acquire();
        t_release();
        t_nonzero();
        t_map();
        t_status();
        t_unmapped();
        t_b2b();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule